// File: doc/BRIEF.md
# Keyed Register Write Protection

This block holds a bank of timer configuration registers and decides, write by write, whether a bus write may land. A single protection-mode register carries an enable flag. While the flag is set, every write aimed at the guarded set is dropped without any error. The guarded set is the two global mode registers and, for each channel, its mode, stepper-mode and three compare/capture registers. A few general-purpose registers stay writable at all times. The flag can change in either direction only through a write whose upper 24 bits hold the unlock key 0x54494D. A write with any other key leaves the flag as it was.

A register-bus master drives an address, a 32-bit data word and a one-cycle strobe. The block registers the outcome and raises `wr_ack` for exactly one cycle after each write that took effect. A separate combinational read port returns the stored value at any mapped address. The enable flag is also brought out directly.

Address map (word addresses): 0x00 protection-mode; 0x01 and 0x02 global modes; 0x04 up to 0x04+NUM_FREE-1 free registers; channel c at 0x10+8*c, with slots 0 to 4 (mode, stepper, compare A, compare B, compare C). Every other address is unmapped.

Top module: `regguard_top`

## Requirements
- R1: After reset the protection flag is 0, every register reads 0 and `wr_ack` is low.
- R2: While protection is off, a write to a guarded register stores the data, and `wr_ack` is high in the following cycle.
- R3: A write to address 0x00 whose bits 31:8 equal 0x54494D sets the protection flag to data bit 0 and is acknowledged.
- R4: A write to address 0x00 with any other value in bits 31:8 is not acknowledged and leaves the protection flag unchanged.
- R5: While protection is on, a write to a guarded register is not acknowledged and leaves that register unchanged.
- R6: A write to a free register (0x04 upward) is stored and acknowledged whether protection is on or off.
- R7: Turning protection off also needs the key: 0x54494D00 at 0x00 clears the flag, after which guarded writes are stored again.
- R8: A write to an unmapped address (0x03, channel slots 5 to 7, beyond the last channel) is not acknowledged and changes no readable state.
- R9: Reading 0x00 returns the flag in bit 0 and zeros in bits 31:1. The key is never stored.
- R10: `wr_ack` is high only in the cycle right after a strobed write that took effect, including back-to-back writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| wr_ack | output | 1 | One-cycle pulse after an accepted write |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Stored value at rd_addr, zero if unmapped |
| prot_on | output | 1 | Current protection flag |

## Verification
The bench builds the block with its defaults: an 8-bit address, 32-bit data, three channels and four free registers. With these values the last slot of the last channel (0x24) can be reached, and so can the unmapped gaps inside a channel stride (0x15) and past the last channel (0x30). A protection change can therefore be tried against guarded, free and unmapped targets in one run. Key values that differ from the unlock key in only one bit and an all-zero word are used to test that a near-miss key is rejected.

// File: rtl/regguard_pkg.sv
package regguard_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PROT,
        RK_GLOBAL,
        RK_FREE,
        RK_CHAN
    } rkind_e;

    // Decoded register target
    typedef struct packed {
        rkind_e     kind;
        logic [7:0] ch;
        logic [7:0] idx;
    } rsel_t;

    localparam int PROT_ADDR   = 0;
    localparam int GLOB_BASE   = 1;
    localparam int GLOB_CNT    = 2;
    localparam int FREE_BASE   = 4;
    localparam int CHAN_BASE   = 16;
    localparam int CHAN_STRIDE = 8;
    localparam int CHAN_SLOTS  = 5;

    localparam int          KEY_LSB    = 8;
    localparam int          KEY_W      = 24;
    localparam logic [23:0] UNLOCK_KEY = 24'h54494D;

endpackage

// File: rtl/regguard_decode.sv
module regguard_decode
    import regguard_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_CH   = 3,
    parameter int NUM_FREE = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output rsel_t             sel
);
    localparam int CHAN_END = CHAN_BASE + NUM_CH * CHAN_STRIDE;

    int a_i;
    int off_i;

    assign a_i   = int'(addr);
    assign off_i = a_i - CHAN_BASE;

    always_comb begin
        sel.kind = RK_NONE;
        sel.ch   = '0;
        sel.idx  = '0;
        if (a_i == PROT_ADDR) begin
            sel.kind = RK_PROT;
        end else if (a_i >= GLOB_BASE && a_i < GLOB_BASE + GLOB_CNT) begin
            sel.kind = RK_GLOBAL;
            sel.idx  = 8'(a_i - GLOB_BASE);
        end else if (a_i >= FREE_BASE && a_i < FREE_BASE + NUM_FREE) begin
            sel.kind = RK_FREE;
            sel.idx  = 8'(a_i - FREE_BASE);
        end else if (a_i >= CHAN_BASE && a_i < CHAN_END
                     && (off_i % CHAN_STRIDE) < CHAN_SLOTS) begin
            sel.kind = RK_CHAN;
            sel.ch   = 8'(off_i / CHAN_STRIDE);
            sel.idx  = 8'(off_i % CHAN_STRIDE);
        end
    end
endmodule

// File: rtl/regguard_policy.sv
module regguard_policy
    import regguard_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  rsel_t             sel,
    input  logic [DATA_W-1:0] data,
    input  logic              prot_q,
    output logic              store,
    output logic              prot_load,
    output logic              accept
);
    logic key_ok;

    assign key_ok = (data[KEY_LSB+KEY_W-1:KEY_LSB] == UNLOCK_KEY);

    always_comb begin
        store     = 1'b0;
        prot_load = 1'b0;
        unique case (sel.kind)
            RK_PROT:           prot_load = wr_en && key_ok;
            RK_GLOBAL, RK_CHAN: store    = wr_en && !prot_q;
            RK_FREE:           store     = wr_en;
            default:           ;
        endcase
        accept = store || prot_load;
    end
endmodule

// File: rtl/regguard_bank.sv
module regguard_bank
    import regguard_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_CH   = 3,
    parameter int NUM_FREE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic              prot_load,
    input  logic              accept,
    input  rsel_t             wsel,
    input  logic [DATA_W-1:0] wdata,
    input  rsel_t             rsel,
    output logic              prot_q,
    output logic              ack_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int GI_W = 1;
    localparam int FI_W = (NUM_FREE > 1) ? $clog2(NUM_FREE) : 1;
    localparam int CI_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SI_W = $clog2(CHAN_SLOTS);

    typedef struct packed {
        logic                                         prot;
        logic                                         ack;
        logic [GLOB_CNT-1:0][DATA_W-1:0]              glob;
        logic [NUM_FREE-1:0][DATA_W-1:0]              free;
        logic [NUM_CH-1:0][CHAN_SLOTS-1:0][DATA_W-1:0] chan;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ack = accept;
        if (prot_load) begin
            s_d.prot = wdata[0];
        end
        if (store) begin
            unique case (wsel.kind)
                RK_GLOBAL: s_d.glob[wsel.idx[GI_W-1:0]] = wdata;
                RK_FREE:   s_d.free[wsel.idx[FI_W-1:0]] = wdata;
                RK_CHAN:   s_d.chan[wsel.ch[CI_W-1:0]][wsel.idx[SI_W-1:0]] = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rsel.kind)
            RK_PROT:   rdata = {{(DATA_W-1){1'b0}}, s_q.prot};
            RK_GLOBAL: rdata = s_q.glob[rsel.idx[GI_W-1:0]];
            RK_FREE:   rdata = s_q.free[rsel.idx[FI_W-1:0]];
            RK_CHAN:   rdata = s_q.chan[rsel.ch[CI_W-1:0]][rsel.idx[SI_W-1:0]];
            default:   ;
        endcase
    end

    assign prot_q = s_q.prot;
    assign ack_q  = s_q.ack;
endmodule

// File: rtl/regguard_top.sv
module regguard_top
    import regguard_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_CH   = 3,
    parameter int NUM_FREE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              prot_on
);
    localparam int NUM_PORTS = 2;

    logic [NUM_PORTS-1:0][ADDR_W-1:0] port_addr;
    rsel_t                            port_sel [NUM_PORTS];

    logic store;
    logic prot_load;
    logic accept;
    logic prot_q;

    assign port_addr[0] = wr_addr;
    assign port_addr[1] = rd_addr;

    // One decoder per access port (0 = write, 1 = read)
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        regguard_decode #(
            .ADDR_W   (ADDR_W),
            .NUM_CH   (NUM_CH),
            .NUM_FREE (NUM_FREE)
        ) u_dec (
            .addr (port_addr[p]),
            .sel  (port_sel[p])
        );
    end

    regguard_policy #(
        .DATA_W (DATA_W)
    ) u_policy (
        .wr_en     (wr_en),
        .sel       (port_sel[0]),
        .data      (wr_data),
        .prot_q    (prot_q),
        .store     (store),
        .prot_load (prot_load),
        .accept    (accept)
    );

    regguard_bank #(
        .DATA_W   (DATA_W),
        .NUM_CH   (NUM_CH),
        .NUM_FREE (NUM_FREE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (store),
        .prot_load (prot_load),
        .accept    (accept),
        .wsel      (port_sel[0]),
        .wdata     (wr_data),
        .rsel      (port_sel[1]),
        .prot_q    (prot_q),
        .ack_q     (wr_ack),
        .rdata     (rd_data)
    );

    assign prot_on = prot_q;
endmodule

// File: rtl/regguard_chk.sv
module regguard_chk
    import regguard_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_CH   = 3,
    parameter int NUM_FREE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_ack,
    input logic              prot_on
);
    int   a_c;
    logic is_prot, is_free, is_guard, key_good;

    assign a_c      = int'(wr_addr);
    assign is_prot  = (a_c == PROT_ADDR);
    assign is_free  = (a_c >= FREE_BASE) && (a_c < FREE_BASE + NUM_FREE);
    assign is_guard = (a_c == 1) || (a_c == 2)
                   || ((a_c >= CHAN_BASE) && (a_c < CHAN_BASE + NUM_CH * CHAN_STRIDE)
                       && ((a_c % CHAN_STRIDE) < CHAN_SLOTS));
    assign key_good = (wr_data[31:8] == 24'h54494D);

    assert_ack_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> $past(wr_en));

    assert_flag_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_on) |-> $past(wr_en && is_prot && key_good));

    assert_bad_key_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_prot && !key_good) |=> (!wr_ack && $stable(prot_on)));

    assert_guard_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prot_on && is_guard) |=> !wr_ack);

    assert_free_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_free) |=> wr_ack);

    assert_keyed_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_prot && key_good) |=> (wr_ack && prot_on == $past(wr_data[0])));
endmodule

bind regguard_top regguard_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CH   (NUM_CH),
    .NUM_FREE (NUM_FREE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_ack  (wr_ack),
    .prot_on (prot_on)
);

// File: tb/regguard_top_tb_top.sv
module regguard_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_ack;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        prot_on;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    logic [31:0] mdl [0:255];
    logic        m_prot = 1'b0;

    typedef struct {
        logic  ack;
        string tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    regguard_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_ack  (wr_ack),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .prot_on (prot_on)
    );

    function automatic bit b_prot(input logic [7:0] a);
        return a == 8'h00;
    endfunction
    function automatic bit b_free(input logic [7:0] a);
        return a >= 8'h04 && a < 8'h08;
    endfunction
    function automatic bit b_guard(input logic [7:0] a);
        return a == 8'h01 || a == 8'h02
            || (a >= 8'h10 && a < 8'h28 && a[2:0] < 3'd5);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: drives one write and pushes the expected acknowledge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        exp_t it;
        logic acc;
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        acc = 1'b0;
        if (b_prot(a)) begin
            if (d[31:8] == 24'h54494D) begin
                acc = 1'b1;
                m_prot = d[0];
            end
        end else if (b_free(a)) begin
            acc = 1'b1;
            mdl[a] = d;
        end else if (b_guard(a)) begin
            acc = !m_prot;
            if (acc) mdl[a] = d;
        end
        it.ack = acc;
        it.tag = req;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        logic [31:0] exp;
        rd_addr = a;
        #1;
        exp = b_prot(a) ? {31'b0, m_prot} : mdl[a];
        chk(req, $sformatf("read %h", a), rd_data, exp);
    endtask

    // Monitor: one comparison of wr_ack per clock, popped from the queue
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            if (mon_on) begin
                if (q.size() > 0) begin
                    it = q.pop_front();
                    #1;
                    chk(it.tag, "wr_ack", {31'b0, wr_ack}, {31'b0, it.ack});
                end else begin
                    #1;
                    chk("R10", "idle wr_ack", {31'b0, wr_ack}, 32'h0);
                end
            end
        end
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "wr_ack", {31'b0, wr_ack}, 32'h0);
        chk("R1", "prot_on", {31'b0, prot_on}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        rd(8'h00, "R1"); rd(8'h01, "R1"); rd(8'h24, "R1"); rd(8'h05, "R1");

        // R2: guarded writes while unprotected
        wr(8'h01, 32'hA5A5_0001, "R2");
        wr(8'h02, 32'h1234_5678, "R2");
        wr(8'h10, 32'h0000_BEEF, "R2");
        wr(8'h14, 32'hCAFE_0014, "R2");
        wr(8'h24, 32'hDEAD_0024, "R2");
        idle();
        rd(8'h01, "R2"); rd(8'h02, "R2"); rd(8'h10, "R2");
        rd(8'h14, "R2"); rd(8'h24, "R2");

        // R4: near-miss key does not enable
        wr(8'h00, 32'h5449_4C01, "R4");
        idle();
        chk("R4", "prot_on", {31'b0, prot_on}, 32'h0);

        // R3: correct key enables; R9: key not stored
        wr(8'h00, 32'h5449_4D01, "R3");
        idle();
        chk("R3", "prot_on", {31'b0, prot_on}, 32'h1);
        rd(8'h00, "R9");

        // R5: guarded writes dropped while protected
        wr(8'h01, 32'hFFFF_FFFF, "R5");
        wr(8'h12, 32'h1111_1111, "R5");
        wr(8'h24, 32'h2222_2222, "R5");
        idle();
        rd(8'h01, "R5"); rd(8'h12, "R5"); rd(8'h24, "R5");

        // R6: free registers writable while protected
        wr(8'h05, 32'h0BAD_F00D, "R6");
        wr(8'h07, 32'h7777_0007, "R6");
        idle();
        rd(8'h05, "R6"); rd(8'h07, "R6");

        // R4: wrong keys do not disable
        wr(8'h00, 32'h0000_0000, "R4");
        wr(8'h00, 32'hD449_4D00, "R4");
        idle();
        chk("R4", "prot_on", {31'b0, prot_on}, 32'h1);

        // R7: keyed disable restores guarded writes
        wr(8'h00, 32'h5449_4D00, "R7");
        idle();
        chk("R7", "prot_on", {31'b0, prot_on}, 32'h0);
        wr(8'h12, 32'h3333_0012, "R7");
        idle();
        rd(8'h12, "R7");

        // R8: unmapped addresses
        wr(8'h03, 32'h9999_0003, "R8");
        wr(8'h15, 32'h9999_0015, "R8");
        wr(8'h30, 32'h9999_0030, "R8");
        idle();
        rd(8'h03, "R8"); rd(8'h15, "R8"); rd(8'h30, "R8");

        // R10: back-to-back writes, mixed outcomes
        wr(8'h04, 32'h4444_0004, "R10");
        wr(8'h00, 32'h5449_4D01, "R10");
        wr(8'h02, 32'h5555_5555, "R10");
        wr(8'h06, 32'h6666_0006, "R10");
        idle();
        idle();
        rd(8'h02, "R10"); rd(8'h04, "R10"); rd(8'h06, "R10");
        chk("R9", "prot_on", {31'b0, prot_on}, 32'h1);
        rd(8'h00, "R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule